// File: doc/BRIEF.md
# Glitch-free clock source switch

This block chooses between two free-running clocks: a slow external reference and a faster internal clock. It drives one output clock that never shows a runt pulse, whichever way the selection changes. A select input, high for internal and low for external, makes the choice. A status output tells the rest of the chip which source currently owns the output.

The two directions are handled differently.

- **External to internal.** The change is sensed on the level of the external clock. As soon as select is high and the external clock is low, the external path is closed at once, so the switch still completes when the external clock has stopped low. The internal path then opens on an internal falling edge, so the first internal rising edge reaches the output whole.
- **Internal to external.** The change is edge based. The internal path closes on an internal falling edge. The external path opens only after synchronizers clocked by the external clock have seen the internal path closed.

Top module: `clk_source_switch`

## Requirements
- R1: While reset is high, the output is low and the status reads 1, which means internal. After reset is released with select high, the output follows the internal clock.
- R2: With select low, the output follows the external clock once the handover is done, and the status reads 0.
- R3: With select high, the output follows the internal clock once the handover is done, and the status reads 1.
- R4: No high or low pulse on the output is shorter than half a period of the faster clock, across every switch in either direction.
- R5: With the external clock stopped low, raising select still completes the switch to the internal clock.
- R6: With the external clock stuck high, raising select never completes the switch: the output stays high and the status stays 0. Once the external clock runs again, the switch completes.
- R7: On an external-to-internal switch, the low gap before the first internal pulse is at least half an internal period. It is at most one and a half internal periods plus the external low time.
- R8: On an internal-to-external switch, the first external rising edge arrives at least one external high time after select falls. It arrives at most one internal period plus (SYNC_STAGES+1) external periods plus one external high time after select falls.
- R9: The two source paths are never open together, so the output stays low for at least one external low time before the first external pulse.
- R10: The status changes only after the new source's path has opened. It never changes while the handover is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| extClk | input | 1 | External reference clock; it may be stopped |
| intClk | input | 1 | Internal clock, the faster of the two, always running |
| rst | input | 1 | Asynchronous reset, active high |
| selInt | input | 1 | Source select: 1 = internal, 0 = external |
| clkOut | output | 1 | Glitch-free muxed clock |
| activeInt | output | 1 | 1 when the internal source drives clkOut, 0 when the external source does |

## Verification
Two events can coincide on an external-to-internal switch:

- the level-sensed closing of the external path, which happens the instant the external clock goes low;
- the internal falling edge that samples whether the external path has closed.

The bench raises select at several phase offsets against both clocks, so that sometimes the external clock is high and sometimes low, and the two events land close together. Each run is judged on two things: the measured low gap must lie inside the R7 bounds, and a running minimum-width monitor on the output must find no pulse narrower than half an internal period.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  // Gate strobes handed from control to datapath
  typedef struct packed {
    logic extPass;
    logic intPass;
  } gateStrobe_t;
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int STAGES  = 2,
  parameter bit ON_FALL = 1'b1
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or posedge clr) begin
        if (clr) chain <= '0;
        else if (STAGES == 1) chain <= d;
        else chain <= {chain[LAST-1:0], d};
      end
    end else begin : g_rise
      always_ff @(posedge clk or posedge clr) begin
        if (clr) chain <= '0;
        else if (STAGES == 1) chain <= d;
        else chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        extClk,
  input  logic        intClk,
  input  logic        rst,
  input  logic        selInt,
  output gateStrobe_t gate,
  output logic        activeInt
);
  logic extEnQ;
  logic intEnQ;
  logic extReq;
  logic extReqSync;
  logic extClr;
  logic extOnSync;

  // Edge-based request for the external path: internal path must be closed first
  assign extReq = ~selInt & ~intEnQ;

  clksw_sync #(.STAGES(SYNC_STAGES), .ON_FALL(1'b1)) u_extSync (
    .clk(extClk), .clr(rst), .d(extReq), .q(extReqSync)
  );

  // Level-sensed park: select high while the external clock is low closes the path at once
  assign extClr = rst | (selInt & ~extClk);

  always_ff @(negedge extClk or posedge extClr) begin
    if (extClr) extEnQ <= 1'b0;
    else        extEnQ <= extReqSync;
  end

  // Internal path opens on an internal falling edge once the external path is shut
  always_ff @(negedge intClk or posedge rst) begin
    if (rst) intEnQ <= 1'b0;
    else     intEnQ <= selInt & ~extEnQ;
  end

  clksw_sync #(.STAGES(SYNC_STAGES), .ON_FALL(1'b0)) u_intSync (
    .clk(intClk), .clr(rst), .d(extEnQ), .q(extOnSync)
  );

  // Status follows the path that has actually opened
  always_ff @(posedge intClk or posedge rst) begin
    if (rst)            activeInt <= 1'b1;
    else if (intEnQ)    activeInt <= 1'b1;
    else if (extOnSync) activeInt <= 1'b0;
  end

  assign gate.extPass = extEnQ;
  assign gate.intPass = intEnQ;

  // R9: never both paths open, seen from the internal domain
  assert_break_before_make_R9: assert property (@(posedge intClk) disable iff (rst)
    !(extEnQ && intEnQ));

  // R9: external path opens only while internal path is shut
  assert_ext_open_clean_R9: assert property (@(posedge extClk) disable iff (rst)
    $rose(extEnQ) |-> !intEnQ);

  // R10: status goes internal only once the internal path was open
  assert_status_to_int_R10: assert property (@(posedge intClk) disable iff (rst)
    $rose(activeInt) |-> $past(intEnQ));

  // R10: status goes external only once the internal path was shut
  assert_status_to_ext_R10: assert property (@(posedge intClk) disable iff (rst)
    $fell(activeInt) |-> !$past(intEnQ));
endmodule

// File: rtl/clksw_path.sv
module clksw_path
  import clksw_pkg::*;
(
  input  logic        extClk,
  input  logic        intClk,
  input  gateStrobe_t gate,
  output logic        clkOut
);
  assign clkOut = (extClk & gate.extPass) | (intClk & gate.intPass);
endmodule

// File: rtl/clk_source_switch.sv
module clk_source_switch
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic extClk,
  input  logic intClk,
  input  logic rst,
  input  logic selInt,
  output logic clkOut,
  output logic activeInt
);
  gateStrobe_t gate;

  clksw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .extClk(extClk), .intClk(intClk), .rst(rst), .selInt(selInt),
    .gate(gate), .activeInt(activeInt)
  );

  clksw_path u_path (
    .extClk(extClk), .intClk(intClk), .gate(gate), .clkOut(clkOut)
  );
endmodule

// File: tb/clk_source_switch_test.sv
`timescale 1ns/1ps
module clk_source_switch_test;
  localparam real TI = 4.0;
  localparam real TEH = 11.3;
  localparam real TE = 22.6;
  localparam int SYNC = 2;

  logic intClk = 1'b0;
  logic extClk = 1'b0;
  logic rst = 1'b1;
  logic selInt = 1'b1;
  logic clkOut;
  logic activeInt;
  bit extRun = 1'b1;
  logic extHold = 1'b0;

  int checks = 0;
  int fails = 0;
  int glitchCnt = 0;
  int riseCnt = 0;
  bit armed = 1'b0;
  realtime lastEdge = 0;
  realtime lastFall = 0;

  clk_source_switch #(.SYNC_STAGES(SYNC)) uut (
    .extClk(extClk), .intClk(intClk), .rst(rst), .selInt(selInt),
    .clkOut(clkOut), .activeInt(activeInt)
  );

  initial forever #2 intClk = ~intClk;
  initial forever begin
    #11.3;
    if (extRun) extClk = ~extClk;
    else        extClk = extHold;
  end

  always @(clkOut) begin
    if (armed && ($realtime - lastEdge) < 1.9) glitchCnt++;
    lastEdge = $realtime;
    if (!clkOut) lastFall = $realtime;
    else riseCnt++;
  end

  task automatic chk(input string tag, input bit ok, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge intClk);
    #1;
  endtask

  // Count output rising edges over 220 ns: about 55 for internal, 9..10 for external
  task automatic follow(input string tag, input bit isInt);
    int n;
    riseCnt = 0;
    #220;
    n = riseCnt;
    if (isInt) chk(tag, n >= 53 && n <= 57, n, 55);
    else       chk(tag, n >= 8 && n <= 11, n, 10);
  endtask

  // fields: [2]=selInt, [1]=expected status, [0]=output follows internal
  localparam logic [2:0] VEC [8] = '{3'b111, 3'b000, 3'b111, 3'b111,
                                     3'b000, 3'b000, 3'b111, 3'b000};

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    realtime t0, gap, dly;
    // R1: reset state
    #30;
    settle();
    chk("R1 out low in reset", clkOut == 1'b0, clkOut, 0);
    chk("R1 status in reset", activeInt == 1'b1, activeInt, 1);
    chk("R1 no pulses in reset", riseCnt == 0, riseCnt, 0);
    #0.5;
    rst = 1'b0;
    armed = 1'b1;
    #50;
    follow("R1 follows internal after reset", 1'b1);

    // Vector table: R2 / R3
    foreach (VEC[i]) begin
      selInt = VEC[i][2];
      #300;
      settle();
      chk(VEC[i][1] ? "R3 status" : "R2 status", activeInt == VEC[i][1], activeInt, VEC[i][1]);
      follow(VEC[i][0] ? "R3 follows internal" : "R2 follows external", VEC[i][0]);
    end

    // R7 / R8 / R9 at several select phases
    for (int k = 0; k < 4; k++) begin
      selInt = 1'b0;
      #300;
      #(k * 7.1 + 0.3);
      selInt = 1'b1;
      @(posedge clkOut);
      gap = $realtime - lastFall;
      chk("R7 gap min", gap >= TI / 2 - 0.1, gap, TI / 2);
      chk("R7 gap max", gap <= 1.5 * TI + TEH + 0.3, gap, 1.5 * TI + TEH);
      #300;
      #(k * 5.3 + 0.3);
      t0 = $realtime;
      selInt = 1'b0;
      forever begin
        @(posedge clkOut);
        if ($realtime - lastFall > 5.0) break;
      end
      dly = $realtime - t0;
      gap = $realtime - lastFall;
      chk("R8 first external edge min", dly >= TEH - 0.3, dly, TEH);
      chk("R8 first external edge max", dly <= TI + (SYNC + 1) * TE + TEH + 0.5, dly,
          TI + (SYNC + 1) * TE + TEH);
      chk("R9 low gap before external", gap >= TEH - 0.3, gap, TEH);
    end

    // R5: external stopped low, switch to internal still completes
    #300;
    @(negedge extClk);
    extHold = 1'b0;
    extRun = 1'b0;
    #5;
    selInt = 1'b1;
    #100;
    settle();
    chk("R5 status after dead-low switch", activeInt == 1'b1, activeInt, 1);
    follow("R5 follows internal", 1'b1);
    extRun = 1'b1;

    // R6 / R10: external stuck high, switch stalls
    selInt = 1'b0;
    #300;
    @(posedge extClk);
    extHold = 1'b1;
    extRun = 1'b0;
    #1;
    selInt = 1'b1;
    #200;
    settle();
    chk("R6 output held high", clkOut == 1'b1, clkOut, 1);
    chk("R10 status unchanged while stalled", activeInt == 1'b0, activeInt, 0);
    extRun = 1'b1;
    #200;
    settle();
    chk("R6 switch completes after resume", activeInt == 1'b1, activeInt, 1);
    follow("R6 follows internal after resume", 1'b1);

    // R4: no runt pulses anywhere so far
    chk("R4 runt pulses", glitchCnt == 0, glitchCnt, 0);

    // R1: mid-run reset from external selection
    selInt = 1'b0;
    #300;
    armed = 1'b0;
    rst = 1'b1;
    selInt = 1'b1;
    #30;
    settle();
    chk("R1 out low in second reset", clkOut == 1'b0, clkOut, 0);
    chk("R1 status in second reset", activeInt == 1'b1, activeInt, 1);
    rst = 1'b0;
    #50;
    follow("R1 follows internal after second reset", 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule